// File: doc/BRIEF.md
# Two-Way Streaming Data Cache

This block is a small set-associative data cache meant for data that streams through a processor once and should not displace long-lived contents elsewhere. It holds two ways per set, 32-byte lines, one parity bit per stored byte and two dirty bits per line. The processor side is a single load/store word port: the core holds a request until a one-cycle response pulse. The memory side carries line fills, partial-line writebacks and single-word reads and writes through one request/acknowledge handshake.

Four mode inputs choose the behaviour at run time. They enable the cache, turn allocation on load misses and on store misses on or off, and select write-through instead of write-back. Replacement alternates between the two ways of each set. A load that hits a line whose addressed bytes fail their parity check raises an error pulse and is served as a miss.

Top module: `mdc_top`

## Requirements
- R1: After reset no line is valid, and `resp_valid`, `mem_valid` and `par_err` are low.
- R2: A load that hits a valid line returns the stored word with `resp_valid` one cycle after the request is first presented, without any memory request.
- R3: With read-allocate on, a load miss issues a line fill (`mem_op` 0) at the line-aligned address, installs the line and then answers from the cache. With read-allocate off, it issues one word read (`mem_op` 2) and no fill.
- R4: In write-back mode a store hit merges the bytes selected by `req_be` and sends nothing to memory. It sets dirty bit 0 for a word in line bytes 0-15 and dirty bit 1 for a word in bytes 16-31.
- R5: In write-through mode a store hit updates the line and forwards the word as a word write (`mem_op` 3). It never sets a dirty bit, so evicting that line causes no writeback.
- R6: With write-allocate on, a store miss fills the line and then writes into it, with no word write. With write-allocate off, it issues one word write and no fill.
- R7: Each set holds a round-robin pointer. It starts at way 0, names the victim of the next fill, and flips after every fill into that set.
- R8: Before a victim with any dirty bit set is replaced, the cache issues a writeback (`mem_op` 1) of that line. `mem_wmask` carries the dirty bits, so memory updates only the dirty 16-byte halves. A clean victim is replaced with no writeback.
- R9: With the cache disabled, every load is a word read and every store a word write. The stored lines, tags and dirty bits are left as they were, so a line cached before disabling still hits with its old contents after re-enabling.
- R10: Fills store the parity bits supplied with the line, and stores compute each parity bit as the XOR of its byte. A load hit whose word fails this check pulses `par_err`, drops that line and is handled as a miss. On the retry straight after a fill, the data is returned and the error is pulsed once more.
- R11: Once raised, `mem_valid` and the request fields stay stable until the cycle `mem_ack` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Cache on; when low every access goes to memory |
| cfg_read_alloc | input | 1 | Allocate a line on a load miss |
| cfg_write_alloc | input | 1 | Allocate a line on a store miss |
| cfg_write_through | input | 1 | Forward every store; never mark lines dirty |
| req_valid | input | 1 | Core request, held until the response |
| req_we | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W | Byte address of the word |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Byte strobes for a store |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Load data, valid with resp_valid |
| par_err | output | 1 | One-cycle parity error pulse |
| mem_valid | output | 1 | Memory request pending |
| mem_op | output | 2 | 0 fill, 1 writeback, 2 word read, 3 word write |
| mem_addr | output | ADDR_W | Line address for fill/writeback, word address otherwise |
| mem_wline | output | LINE_BYTES*8 | Line data for a writeback |
| mem_wmask | output | 2 | Halves of the line to write back |
| mem_wword | output | 32 | Word write data |
| mem_wbe | output | 4 | Word write byte strobes |
| mem_ack | input | 1 | Memory completes the pending request |
| mem_rline | input | LINE_BYTES*8 | Fill data, valid with mem_ack |
| mem_rpar | input | LINE_BYTES | Per-byte parity of the fill data |
| mem_rword | input | 32 | Word read data, valid with mem_ack |

## Verification
The bench builds the cache with four sets and keeps the 32-byte line and 32-bit address defaults, against a 2 KB memory model. Four sets let a short sequence of same-set addresses force both replacement choices and dirty evictions of either half. A sweep over 512 bytes then cycles every set through four distinct tags and checks every word, with one fill expected per line and one-cycle hits for the remaining words. The memory model can corrupt the parity of one fill, which reaches the error path from the ports.

// File: rtl/mdc_pkg.sv
package mdc_pkg;

    typedef enum logic [1:0] {
        MOP_FILL = 2'd0,
        MOP_WB   = 2'd1,
        MOP_RD   = 2'd2,
        MOP_WR   = 2'd3
    } mem_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WB,
        ST_FILL,
        ST_BYPR,
        ST_BYPW
    } st_e;

    // one parity bit per byte: XOR of its eight bits
    function automatic logic [3:0] word_par(input logic [31:0] w);
        logic [3:0] p;
        for (int b = 0; b < 4; b++) begin
            p[b] = ^w[b*8 +: 8];
        end
        return p;
    endfunction

endpackage

// File: rtl/mdc_way.sv
module mdc_way #(
    parameter int SETS       = 32,
    parameter int TAG_W      = 22,
    parameter int LINE_BYTES = 32,
    localparam int IDX_W     = $clog2(SETS),
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int WSEL_W    = $clog2(LINE_BYTES / 4)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      idx,
    output logic                  rd_valid,
    output logic [TAG_W-1:0]      rd_tag,
    output logic [LINE_W-1:0]     rd_line,
    output logic [LINE_BYTES-1:0] rd_par,
    output logic [1:0]            rd_dirty,
    input  logic                  fill_en,
    input  logic [TAG_W-1:0]      fill_tag,
    input  logic [LINE_W-1:0]     fill_line,
    input  logic [LINE_BYTES-1:0] fill_par,
    input  logic                  inv_en,
    input  logic                  word_en,
    input  logic [WSEL_W-1:0]     word_sel,
    input  logic [3:0]            word_be,
    input  logic [31:0]           word_data,
    input  logic                  word_dirty
);

    logic [LINE_W-1:0]     line_m [SETS];
    logic [LINE_BYTES-1:0] par_m  [SETS];
    logic [TAG_W-1:0]      tag_m  [SETS];
    logic [1:0]            dirty_q [SETS];
    logic [SETS-1:0]       valid_q;

    assign rd_valid = valid_q[idx];
    assign rd_tag   = tag_m[idx];
    assign rd_line  = line_m[idx];
    assign rd_par   = par_m[idx];
    assign rd_dirty = dirty_q[idx];

    // payload storage, no reset needed
    always_ff @(posedge clk) begin
        if (fill_en) begin
            line_m[idx] <= fill_line;
            par_m[idx]  <= fill_par;
            tag_m[idx]  <= fill_tag;
        end else if (word_en) begin
            for (int b = 0; b < 4; b++) begin
                if (word_be[b]) begin
                    line_m[idx][(int'(word_sel) * 4 + b) * 8 +: 8] <= word_data[b*8 +: 8];
                    par_m[idx][int'(word_sel) * 4 + b]             <= ^word_data[b*8 +: 8];
                end
            end
        end
    end

    // line state bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                dirty_q[s] <= '0;
            end
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= '0;
        end else if (inv_en) begin
            valid_q[idx] <= 1'b0;
            dirty_q[idx] <= '0;
        end else if (word_en && word_dirty) begin
            dirty_q[idx][word_sel[WSEL_W-1]] <= 1'b1;
        end
    end

    // R4
    fill_word_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !word_en && !inv_en);

endmodule

// File: rtl/mdc_rr.sv
module mdc_rr #(
    parameter int SETS   = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             adv_en,
    output logic             victim
);

    logic [SETS-1:0] ptr_d, ptr_q;

    assign victim = ptr_q[idx];

    always_comb begin
        ptr_d = ptr_q;
        if (adv_en) begin
            ptr_d[idx] = ~ptr_q[idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    // R7
    rr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |=> ptr_q[$past(idx)] != $past(ptr_q[idx]));

endmodule

// File: rtl/mdc_top.sv
module mdc_top
    import mdc_pkg::*;
#(
    parameter int SETS       = 32,
    parameter int LINE_BYTES = 32,
    parameter int ADDR_W     = 32,
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_enable,
    input  logic                  cfg_read_alloc,
    input  logic                  cfg_write_alloc,
    input  logic                  cfg_write_through,
    input  logic                  req_valid,
    input  logic                  req_we,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [31:0]           req_wdata,
    input  logic [3:0]            req_be,
    output logic                  resp_valid,
    output logic [31:0]           resp_rdata,
    output logic                  par_err,
    output logic                  mem_valid,
    output logic [1:0]            mem_op,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LINE_W-1:0]     mem_wline,
    output logic [1:0]            mem_wmask,
    output logic [31:0]           mem_wword,
    output logic [3:0]            mem_wbe,
    input  logic                  mem_ack,
    input  logic [LINE_W-1:0]     mem_rline,
    input  logic [LINE_BYTES-1:0] mem_rpar,
    input  logic [31:0]           mem_rword
);

    localparam int WAYS   = 2;
    localparam int IDX_W  = $clog2(SETS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int WSEL_W = $clog2(LINE_BYTES / 4);

    typedef struct packed {
        st_e               st;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       wdata;
        logic [3:0]        be;
        logic              vic;
        logic              retry;
        logic              resp;
        logic [31:0]       rdata;
        logic              perr;
    } ctl_t;

    ctl_t s_d, s_q;

    logic                  w_valid [WAYS];
    logic [TAG_W-1:0]      w_tag   [WAYS];
    logic [LINE_W-1:0]     w_line  [WAYS];
    logic [LINE_BYTES-1:0] w_par   [WAYS];
    logic [1:0]            w_dirty [WAYS];
    logic                  w_fill  [WAYS];
    logic                  w_inv   [WAYS];
    logic                  w_word  [WAYS];
    logic                  word_dirty;
    logic                  rr_vic, rr_adv;

    logic [IDX_W-1:0]  idx_sel;
    logic [TAG_W-1:0]  tag_live;
    logic [WSEL_W-1:0] wsel_live;
    logic [WAYS-1:0]   hit;
    logic              hit_any, hway, bad;
    logic [31:0]       hword;
    logic [3:0]        hpar;

    assign idx_sel   = (s_q.st == ST_IDLE) ? req_addr[OFF_W +: IDX_W] : s_q.addr[OFF_W +: IDX_W];
    assign tag_live  = req_addr[ADDR_W-1 -: TAG_W];
    assign wsel_live = req_addr[2 +: WSEL_W];

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        mdc_way #(
            .SETS       (SETS),
            .TAG_W      (TAG_W),
            .LINE_BYTES (LINE_BYTES)
        ) u_way (
            .clk        (clk),
            .rst_n      (rst_n),
            .idx        (idx_sel),
            .rd_valid   (w_valid[g]),
            .rd_tag     (w_tag[g]),
            .rd_line    (w_line[g]),
            .rd_par     (w_par[g]),
            .rd_dirty   (w_dirty[g]),
            .fill_en    (w_fill[g]),
            .fill_tag   (s_q.addr[ADDR_W-1 -: TAG_W]),
            .fill_line  (mem_rline),
            .fill_par   (mem_rpar),
            .inv_en     (w_inv[g]),
            .word_en    (w_word[g]),
            .word_sel   (wsel_live),
            .word_be    (req_be),
            .word_data  (req_wdata),
            .word_dirty (word_dirty)
        );
        assign hit[g] = w_valid[g] && (w_tag[g] == tag_live);
    end

    mdc_rr #(.SETS(SETS)) u_rr (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (idx_sel),
        .adv_en (rr_adv),
        .victim (rr_vic)
    );

    assign hit_any = |hit;
    assign hway    = hit[1];
    assign hword   = w_line[hway][int'(wsel_live) * 32 +: 32];
    assign hpar    = w_par[hway][int'(wsel_live) * 4 +: 4];
    assign bad     = hpar != word_par(hword);

    always_comb begin
        s_d        = s_q;
        s_d.resp   = 1'b0;
        s_d.perr   = 1'b0;
        rr_adv     = 1'b0;
        word_dirty = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            w_fill[w] = 1'b0;
            w_inv[w]  = 1'b0;
            w_word[w] = 1'b0;
        end
        mem_valid = 1'b0;
        mem_op    = MOP_FILL;
        mem_addr  = '0;
        mem_wline = '0;
        mem_wmask = '0;
        mem_wword = '0;
        mem_wbe   = '0;

        case (s_q.st)
            ST_IDLE: begin
                if (req_valid && !s_q.resp) begin
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                    s_d.be    = req_be;
                    if (!cfg_enable) begin
                        s_d.retry = 1'b0;
                        s_d.st    = req_we ? ST_BYPW : ST_BYPR;
                    end else if (!req_we) begin
                        if (hit_any && (!bad || s_q.retry)) begin
                            s_d.resp  = 1'b1;
                            s_d.rdata = hword;
                            s_d.perr  = bad;
                            s_d.retry = 1'b0;
                        end else if (hit_any) begin
                            s_d.perr    = 1'b1;
                            w_inv[hway] = 1'b1;
                        end else if (cfg_read_alloc) begin
                            s_d.vic = rr_vic;
                            s_d.st  = (w_valid[rr_vic] && |w_dirty[rr_vic]) ? ST_WB : ST_FILL;
                        end else begin
                            s_d.st = ST_BYPR;
                        end
                    end else begin
                        if (hit_any) begin
                            w_word[hway] = 1'b1;
                            word_dirty   = !cfg_write_through;
                            s_d.retry    = 1'b0;
                            if (cfg_write_through) begin
                                s_d.st = ST_BYPW;
                            end else begin
                                s_d.resp = 1'b1;
                            end
                        end else if (cfg_write_alloc) begin
                            s_d.vic = rr_vic;
                            s_d.st  = (w_valid[rr_vic] && |w_dirty[rr_vic]) ? ST_WB : ST_FILL;
                        end else begin
                            s_d.st = ST_BYPW;
                        end
                    end
                end
            end
            ST_WB: begin
                mem_valid = 1'b1;
                mem_op    = MOP_WB;
                mem_addr  = {w_tag[s_q.vic], idx_sel, {OFF_W{1'b0}}};
                mem_wline = w_line[s_q.vic];
                mem_wmask = w_dirty[s_q.vic];
                if (mem_ack) begin
                    s_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_op    = MOP_FILL;
                mem_addr  = {s_q.addr[ADDR_W-1 -: TAG_W], idx_sel, {OFF_W{1'b0}}};
                if (mem_ack) begin
                    w_fill[s_q.vic] = 1'b1;
                    rr_adv          = 1'b1;
                    s_d.retry       = 1'b1;
                    s_d.st          = ST_IDLE;
                end
            end
            ST_BYPR: begin
                mem_valid = 1'b1;
                mem_op    = MOP_RD;
                mem_addr  = s_q.addr;
                if (mem_ack) begin
                    s_d.resp  = 1'b1;
                    s_d.rdata = mem_rword;
                    s_d.retry = 1'b0;
                    s_d.st    = ST_IDLE;
                end
            end
            ST_BYPW: begin
                mem_valid = 1'b1;
                mem_op    = MOP_WR;
                mem_addr  = s_q.addr;
                mem_wword = s_q.wdata;
                mem_wbe   = s_q.be;
                if (mem_ack) begin
                    s_d.resp = 1'b1;
                    s_d.st   = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign resp_valid = s_q.resp;
    assign resp_rdata = s_q.rdata;
    assign par_err    = s_q.perr;

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ack |=> mem_valid && $stable(mem_addr) && $stable(mem_op));

    // R8
    wb_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_op == 2'd1 |-> mem_wmask != 2'b00);

    // R9
    fill_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_op == 2'd0 |-> cfg_enable);

    // R2
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

endmodule

// File: tb/sim_mdc_top.sv
`timescale 1ns/1ps
module sim_mdc_top;
    import mdc_pkg::*;

    localparam int SETS = 4;
    localparam int LB   = 32;
    localparam int AW   = 32;
    localparam int LW   = LB * 8;
    localparam int MW   = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_enable = 1'b0, cfg_read_alloc = 1'b1, cfg_write_alloc = 1'b1, cfg_write_through = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0] req_be = '0;
    logic resp_valid, par_err, mem_valid;
    logic [31:0] resp_rdata, mem_wword;
    logic [1:0] mem_op, mem_wmask;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_wline;
    logic [3:0] mem_wbe;
    logic mem_ack = 1'b0;
    logic [LW-1:0] mem_rline = '0;
    logic [LB-1:0] mem_rpar = '0;
    logic [31:0] mem_rword = '0;

    always #4 clk = ~clk;

    mdc_top #(.SETS(SETS), .LINE_BYTES(LB), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_enable(cfg_enable), .cfg_read_alloc(cfg_read_alloc),
        .cfg_write_alloc(cfg_write_alloc), .cfg_write_through(cfg_write_through),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .par_err(par_err),
        .mem_valid(mem_valid), .mem_op(mem_op), .mem_addr(mem_addr),
        .mem_wline(mem_wline), .mem_wmask(mem_wmask), .mem_wword(mem_wword),
        .mem_wbe(mem_wbe), .mem_ack(mem_ack), .mem_rline(mem_rline),
        .mem_rpar(mem_rpar), .mem_rword(mem_rword)
    );

    logic [31:0] mem    [MW];
    logic [31:0] shadow [MW];
    int checks = 0, errors = 0;
    int n_fill = 0, n_wb = 0, n_rd = 0, n_wr = 0;
    logic [1:0]  last_wb_mask = '0;
    logic [31:0] last_wb_addr = '0, last_fill_addr = '0;
    bit corrupt_fill = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: two idle cycles, then a one-cycle acknowledge
    initial begin
        for (int i = 0; i < MW; i++) begin
            mem[i]    = 32'h3C00_0000 ^ (i * 32'h0101_0103);
            shadow[i] = mem[i];
        end
        forever begin
            @(negedge clk);
            if (mem_valid) begin
                repeat (2) @(negedge clk);
                case (mem_op)
                    2'd0: begin
                        n_fill++;
                        last_fill_addr = mem_addr;
                        for (int w = 0; w < 8; w++) begin
                            mem_rline[w*32 +: 32] = mem[{mem_addr[10:5], 3'(w)}];
                        end
                        for (int k = 0; k < LB; k++) begin
                            mem_rpar[k] = (^mem_rline[k*8 +: 8]) ^ corrupt_fill;
                        end
                        corrupt_fill = 1'b0;
                    end
                    2'd1: begin
                        n_wb++;
                        last_wb_mask = mem_wmask;
                        last_wb_addr = mem_addr;
                        for (int w = 0; w < 8; w++) begin
                            if (mem_wmask[w / 4]) mem[{mem_addr[10:5], 3'(w)}] = mem_wline[w*32 +: 32];
                        end
                    end
                    2'd2: begin
                        n_rd++;
                        mem_rword = mem[mem_addr[10:2]];
                    end
                    default: begin
                        n_wr++;
                        for (int b = 0; b < 4; b++) begin
                            if (mem_wbe[b]) mem[mem_addr[10:2]][b*8 +: 8] = mem_wword[b*8 +: 8];
                        end
                    end
                endcase
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] be, output logic [31:0] rd, output int lat, output bit pe);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        lat = 0; pe = 1'b0;
        do begin
            @(negedge clk);
            lat++;
            if (par_err) pe = 1'b1;
        end while (!resp_valid);
        rd = resp_rdata;
        req_valid = 1'b0;
        if (we) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) shadow[a[10:2]][b*8 +: 8] = d[b*8 +: 8];
            end
        end
    endtask

    task automatic ld(input logic [31:0] a, input string tag, output int lat, output bit pe);
        logic [31:0] rd;
        access(1'b0, a, '0, '0, rd, lat, pe);
        chk(rd === shadow[a[10:2]], tag, rd, shadow[a[10:2]]);
    endtask

    task automatic st(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, output int lat);
        logic [31:0] rd;
        bit pe;
        access(1'b1, a, d, be, rd, lat, pe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat, f0, w0, r0, wr0;
        bit pe;
        logic [31:0] old, rd;

        repeat (3) @(negedge clk);
        // R1: idle outputs during reset and just after release
        chk(!resp_valid && !mem_valid && !par_err, "R1 reset outputs", {resp_valid, mem_valid, par_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!resp_valid && !mem_valid && !par_err, "R1 after release", {resp_valid, mem_valid, par_err}, 0);

        // R9: disabled accesses go straight to memory as word operations
        ld(32'h004, "R9 disabled load data", lat, pe);
        chk(n_rd == 1 && n_fill == 0, "R9 disabled load is word read", n_rd, 1);
        st(32'h008, 32'h1122_3344, 4'hF, lat);
        chk(n_wr == 1 && n_fill == 0, "R9 disabled store is word write", n_wr, 1);

        // R3: read-allocate miss fetches the aligned line
        cfg_enable = 1'b1;
        ld(32'h000, "R3 miss data", lat, pe);
        chk(n_fill == 1 && last_fill_addr == 32'h000, "R3 fill address", last_fill_addr, 0);
        chk(lat > 1, "R3 miss latency", lat, 2);
        // R2: rest of the line hits in one cycle with no traffic
        for (int w = 0; w < 8; w++) begin
            ld(32'(w * 4), "R2 hit data", lat, pe);
            chk(lat == 1 && n_fill == 1 && n_rd == 1, "R2 hit latency", lat, 1);
        end

        // R4: write-back store hit, low half
        st(32'h004, 32'hDEAD_BEEF, 4'b0011, lat);
        chk(lat == 1 && n_wr == 1 && n_fill == 1, "R4 store hit no traffic", lat, 1);
        ld(32'h004, "R4 merged bytes", lat, pe);

        // R7/R8: round robin in set 0, dirty low half written back
        ld(32'h080, "R7 second way", lat, pe);
        chk(n_wb == 0 && n_fill == 2, "R7 fill into empty way", n_wb, 0);
        ld(32'h100, "R8 evict dirty", lat, pe);
        chk(n_wb == 1 && last_wb_addr == 32'h000, "R8 writeback address", last_wb_addr, 0);
        chk(last_wb_mask == 2'b01, "R8 mask low half", last_wb_mask, 2'b01);
        chk(mem[1] == shadow[1], "R8 memory updated", mem[1], shadow[1]);
        ld(32'h000, "R7 reload evicts clean way", lat, pe);
        chk(n_wb == 1 && n_fill == 4, "R7 clean victim no writeback", n_wb, 1);
        // R4: high half dirty
        st(32'h01C, 32'hCAFE_F00D, 4'hF, lat);
        chk(lat == 1, "R4 high half store hit", lat, 1);
        ld(32'h080, "R7 evict way0", lat, pe);
        chk(n_wb == 1, "R7 way0 clean", n_wb, 1);
        ld(32'h180, "R8 evict way1", lat, pe);
        chk(n_wb == 2 && last_wb_mask == 2'b10, "R8 mask high half", last_wb_mask, 2'b10);
        chk(mem[7] == shadow[7] && mem[0] == shadow[0], "R8 only dirty half", mem[7], shadow[7]);

        // R2/R3 sweep: four tags per set, every word
        for (int a = 32'h200; a < 32'h400; a += 4) begin
            f0 = n_fill;
            ld(32'(a), "R3 sweep data", lat, pe);
            if (a % 32 == 0) chk(n_fill == f0 + 1, "R3 sweep one fill per line", n_fill - f0, 1);
            else chk(n_fill == f0 && lat == 1, "R2 sweep hit", lat, 1);
        end

        // R5: write-through
        cfg_write_through = 1'b1;
        ld(32'h020, "R5 prime line", lat, pe);
        wr0 = n_wr; f0 = n_fill; w0 = n_wb;
        st(32'h024, 32'h5A5A_A5A5, 4'b1010, lat);
        chk(n_wr == wr0 + 1 && n_fill == f0, "R5 store forwarded", n_wr - wr0, 1);
        chk(mem[9] == shadow[9], "R5 memory word", mem[9], shadow[9]);
        ld(32'h0A0, "R5 evict a", lat, pe);
        ld(32'h120, "R5 evict b", lat, pe);
        chk(n_wb == w0, "R5 no writeback", n_wb - w0, 0);
        ld(32'h024, "R5 refetch value", lat, pe);
        cfg_write_through = 1'b0;

        // R3: no read-allocate
        cfg_read_alloc = 1'b0;
        f0 = n_fill; r0 = n_rd;
        ld(32'h444, "R3 no-alloc load", lat, pe);
        chk(n_rd == r0 + 1 && n_fill == f0, "R3 no-alloc word read", n_rd - r0, 1);
        // R6: no write-allocate
        cfg_write_alloc = 1'b0;
        wr0 = n_wr;
        st(32'h448, 32'h0BAD_F00D, 4'hF, lat);
        chk(n_wr == wr0 + 1 && n_fill == f0, "R6 no-alloc word write", n_wr - wr0, 1);
        ld(32'h448, "R6 no-alloc readback", lat, pe);
        // R6: write-allocate
        cfg_write_alloc = 1'b1; cfg_read_alloc = 1'b1;
        wr0 = n_wr;
        st(32'h464, 32'h7777_1234, 4'hF, lat);
        chk(n_fill == f0 + 1 && n_wr == wr0, "R6 alloc fills, no word write", n_fill - f0, 1);
        ld(32'h464, "R6 alloc readback", lat, pe);
        chk(lat == 1, "R6 alloc hit after", lat, 1);

        // R10: corrupted fill parity
        corrupt_fill = 1'b1;
        f0 = n_fill;
        ld(32'h500, "R10 retry data", lat, pe);
        chk(pe, "R10 error on retry", pe, 1);
        ld(32'h500, "R10 refetch data", lat, pe);
        chk(pe && n_fill == f0 + 2, "R10 refetch after error", n_fill - f0, 2);
        ld(32'h500, "R10 clean hit", lat, pe);
        chk(!pe && lat == 1, "R10 no error on good line", pe, 0);

        // R9: disabled store leaves cached line untouched
        ld(32'h540, "R9 prime", lat, pe);
        old = shadow[32'h540 >> 2];
        cfg_enable = 1'b0;
        st(32'h540, 32'hFEED_0001, 4'hF, lat);
        ld(32'h540, "R9 disabled load sees memory", lat, pe);
        cfg_enable = 1'b1;
        access(1'b0, 32'h540, '0, '0, rd, lat, pe);
        chk(rd == old && lat == 1, "R9 cached contents unchanged", rd, old);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule